// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block gathers the interrupt requests of a four-channel serial controller: one receive source and one transmit source per channel, eight sources in all. Each source comes in as a status-flag and enable pair. A request latch per source captures the moment both become true. The block ranks the pending latches with a fixed priority and raises the bus request line of the interrupt level it has been configured to use. When the bus acknowledge reaches it, it either answers with the vector of the winning source or, if it has nothing to offer or a device on a higher level is requesting, passes the acknowledge further down the chain.

Vectors are formed from a configurable base, the channel number and the direction. A console mode gives the last channel a pair of fixed vectors that do not depend on the base. Only the winning source is cleared on a grant, so lower-ranked requests stay pending for the next acknowledge cycle.

Top module: `irq_vector_arb`

## Requirements
- R1: A source's request latch is set on the clock edge where (flag AND enable) of that source is first seen true after being false. A flag with its enable low, or an enable with its flag low, sets nothing. Source index i in 0..3 is the receive source of channel i, and index 4..7 is the transmit source of channel i-4.
- R2: A pending source whose enable goes low drops its request on the next clock edge.
- R3: While any request is pending, exactly one bit of `irq_out` is high, the bit given by `level_sel` (bit 0 = level 4 up to bit 3 = level 7). With nothing pending, `irq_out` is all zero.
- R4: Priority runs from highest to lowest as rx0, rx1, rx2, rx3, tx0, tx1, tx2, tx3, that is, from index 0 to index 7.
- R5: Outside console mode, the vector of the receive source of channel c is base_sel*32 + 8*c, and the vector of the transmit source is base_sel*32 + 8*c + 4. base_sel is 4 bits wide, so the base runs from 0 to octal 740 in steps of octal 40.
- R6: With `console_en` high, the channel 3 receive vector is octal 60 (48) and the channel 3 transmit vector is octal 64 (52), whatever the value of base_sel.
- R7: A rising `iack_in` is sampled at a clock edge. If the block takes the grant, `vec_valid` is high with the winner's vector on `vec_out` from that edge on, and the winner alone is cleared at that same edge. `vec_valid` falls at the first edge that sees `iack_in` low.
- R8: If any `hi_req_mon` bit above `level_sel` is high when the rising acknowledge is sampled, the block does not take the grant. It raises `iack_out` instead, drives no vector, and clears nothing.
- R9: If nothing is pending when the rising acknowledge is sampled, `iack_out` goes high from that edge until the first edge that sees `iack_in` low. `vec_valid` stays low and `vec_out` reads zero.
- R10: During reset, `irq_out`, `vec_valid`, `vec_out` and `iack_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag | input | 8 | Status flag of each source (rx0..rx3, tx0..tx3) |
| src_en | input | 8 | Interrupt enable of each source |
| base_sel | input | 4 | Vector base in units of 32 |
| console_en | input | 1 | Gives channel 3 the fixed console vectors |
| level_sel | input | 2 | Request level: 0..3 select level 4..7 |
| hi_req_mon | input | 4 | Observed bus request lines of levels 4..7 |
| iack_in | input | 1 | Incoming interrupt acknowledge |
| irq_out | output | 4 | Bus request lines of levels 4..7 |
| vec_out | output | 9 | Vector value, zero when not valid |
| vec_valid | output | 1 | Vector is being driven |
| iack_out | output | 1 | Acknowledge passed down the chain |

## Verification
The assertions take for granted that `iack_in` is a level that stays high until the block has answered, and that it returns low before it rises again. They also take for granted that a source is not raised in the same cycle as the edge that grants it. The stimulus holds `iack_in` high for exactly one edge and drops it at the next sample point. It pulses flags only in cycles with no acknowledge in flight, and it changes the level, base and monitor lines only while the acknowledge is low.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_VEC  = 2'd1,
    ACK_PASS = 2'd2
  } ack_state_e;

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic en,
  input  logic clr,
  output logic pend
);

  logic cond;
  logic cond_q;
  logic pend_q;
  logic pend_d;

  assign cond = flag & en;

  always_comb begin
    pend_d = pend_q & ~clr;
    if (cond && !cond_q) begin
      pend_d = 1'b1;
    end
    if (!en) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cond_q <= cond;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N   = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);

  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        grant = N'(1) << i;
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
  parameter int NCH    = 4,
  parameter int VEC_W  = 9,
  parameter int BASE_W = 4,
  parameter logic [VEC_W-1:0] CONS_RX_VEC = 9'o060,
  parameter logic [VEC_W-1:0] CONS_TX_VEC = 9'o064
) (
  input  logic [$clog2(2*NCH)-1:0] idx,
  input  logic [BASE_W-1:0]        base_sel,
  input  logic                     console_en,
  output logic [VEC_W-1:0]         vec
);

  localparam int CH_W  = $clog2(NCH);
  localparam int SRC_W = $clog2(2*NCH);
  localparam int BASE_SHIFT = CH_W + 3;

  logic [CH_W-1:0] ch;
  logic            is_tx;
  logic [VEC_W-1:0] plain_vec;

  assign ch    = idx[CH_W-1:0];
  assign is_tx = idx[SRC_W-1];

  assign plain_vec = (VEC_W'(base_sel) << BASE_SHIFT)
                   | (VEC_W'(ch) << 3)
                   | (VEC_W'(is_tx) << 2);

  always_comb begin
    vec = plain_vec;
    if (console_en && (ch == CH_W'(NCH - 1))) begin
      vec = is_tx ? CONS_TX_VEC : CONS_RX_VEC;
    end
  end

endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb
  import irq_arb_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NLVL   = 4,
  parameter int VEC_W  = 9,
  parameter int BASE_W = VEC_W - $clog2(NCH) - 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2*NCH-1:0]         src_flag,
  input  logic [2*NCH-1:0]         src_en,
  input  logic [BASE_W-1:0]        base_sel,
  input  logic                     console_en,
  input  logic [$clog2(NLVL)-1:0]  level_sel,
  input  logic [NLVL-1:0]          hi_req_mon,
  input  logic                     iack_in,
  output logic [NLVL-1:0]          irq_out,
  output logic [VEC_W-1:0]         vec_out,
  output logic                     vec_valid,
  output logic                     iack_out
);

  localparam int NSRC  = 2 * NCH;
  localparam int SRC_W = $clog2(NSRC);
  localparam int LVL_W = $clog2(NLVL);

  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  clr;
  logic [NSRC-1:0]  grant;
  logic             any;
  logic [SRC_W-1:0] win_idx;
  logic [VEC_W-1:0] win_vec;

  ack_state_e       state_q, state_d;
  logic             iack_q;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             iack_rise;
  logic             blocked;
  logic             take;

  // per-source request latches
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_req_latch u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .flag (src_flag[s]),
      .en   (src_en[s]),
      .clr  (clr[s]),
      .pend (pend[s])
    );
  end

  irq_prio_pick #(.N(NSRC)) u_pick (
    .req  (pend),
    .any  (any),
    .idx  (win_idx),
    .grant(grant)
  );

  irq_vec_calc #(.NCH(NCH), .VEC_W(VEC_W), .BASE_W(BASE_W)) u_vec (
    .idx       (win_idx),
    .base_sel  (base_sel),
    .console_en(console_en),
    .vec       (win_vec)
  );

  // bus request line of the configured level
  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    assign irq_out[l] = any & (level_sel == LVL_W'(l));
  end

  // a device on a strictly higher level is requesting
  always_comb begin
    blocked = 1'b0;
    for (int j = 0; j < NLVL; j++) begin
      if ((LVL_W'(j) > level_sel) && hi_req_mon[j]) begin
        blocked = 1'b1;
      end
    end
  end

  assign iack_rise = iack_in & ~iack_q;
  assign take      = iack_rise & (state_q == ACK_IDLE) & any & ~blocked;
  assign clr       = take ? grant : '0;

  always_comb begin
    state_d = state_q;
    vec_d   = vec_q;
    if (!iack_in) begin
      state_d = ACK_IDLE;
    end else if (iack_rise && (state_q == ACK_IDLE)) begin
      if (take) begin
        state_d = ACK_VEC;
        vec_d   = win_vec;
      end else begin
        state_d = ACK_PASS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      iack_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      iack_q  <= iack_in;
      if (take) begin
        vec_q <= vec_d;
      end
    end
  end

  assign vec_valid = (state_q == ACK_VEC);
  assign iack_out  = (state_q == ACK_PASS);
  assign vec_out   = vec_valid ? vec_q : '0;

endmodule

// File: rtl/irq_vector_arb_chk.sv
module irq_vector_arb_chk #(
  parameter int NLVL  = 4,
  parameter int VEC_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iack_in,
  input logic [NLVL-1:0]  irq_out,
  input logic [VEC_W-1:0] vec_out,
  input logic             vec_valid,
  input logic             iack_out
);

  logic ck_iack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_iack_q <= 1'b0;
    end else begin
      ck_iack_q <= iack_in;
    end
  end

  assert_single_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_out));

  assert_vec_xor_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && iack_out));

  assert_vec_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> ck_iack_q);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_in |=> (!vec_valid && !iack_out));

  assert_pass_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack_out) |-> ck_iack_q);

  assert_empty_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_in && !ck_iack_q && (irq_out == '0)) |=> (iack_out && !vec_valid));

  assert_vec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_out == '0));

endmodule

bind irq_vector_arb irq_vector_arb_chk #(.NLVL(NLVL), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iack_in  (iack_in),
  .irq_out  (irq_out),
  .vec_out  (vec_out),
  .vec_valid(vec_valid),
  .iack_out (iack_out)
);

// File: tb/test_irq_vector_arb.sv
module test_irq_vector_arb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] src_flag;
  logic [7:0] src_en;
  logic [3:0] base_sel;
  logic       console_en;
  logic [1:0] level_sel;
  logic [3:0] hi_req_mon;
  logic       iack_in;
  logic [3:0] irq_out;
  logic [8:0] vec_out;
  logic       vec_valid;
  logic       iack_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] mpend = '0;

  always #2 clk = ~clk;

  irq_vector_arb i_irq_vector_arb (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .base_sel(base_sel), .console_en(console_en), .level_sel(level_sel),
    .hi_req_mon(hi_req_mon), .iack_in(iack_in), .irq_out(irq_out),
    .vec_out(vec_out), .vec_valid(vec_valid), .iack_out(iack_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_vec(input int idx);
    int ch = idx % 4;
    int tx = idx / 4;
    if (console_en && ch == 3) return tx ? 52 : 48;
    return int'(base_sel) * 32 + ch * 8 + tx * 4;
  endfunction

  function automatic int winner(input logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic bit is_blocked();
    for (int j = 0; j < 4; j++) if (j > int'(level_sel) && hi_req_mon[j]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_irq(input string req);
    int e = (mpend != 0) ? (1 << level_sel) : 0;
    check(int'(irq_out) == e, req, int'(irq_out), e);
  endtask

  // pulse flags (enables assumed high for the pulsed bits); sample after
  task automatic pulse_src(input logic [7:0] mask);
    @(negedge clk);
    src_flag = mask;
    @(negedge clk);
    src_flag = '0;
    mpend |= mask & src_en;
  endtask

  task automatic do_ack(input string req);
    int w = winner(mpend);
    bit blk = is_blocked();
    @(negedge clk);
    iack_in = 1'b1;
    @(negedge clk);
    if (w >= 0 && !blk) begin
      check(vec_valid == 1'b1, req, int'(vec_valid), 1);
      check(int'(vec_out) == exp_vec(w), req, int'(vec_out), exp_vec(w));
      check(iack_out == 1'b0, req, int'(iack_out), 0);
      mpend[w] = 1'b0;
    end else begin
      check(iack_out == 1'b1, req, int'(iack_out), 1);
      check(vec_valid == 1'b0 && vec_out == '0, req, int'(vec_out), 0);
    end
    iack_in = 1'b0;
    @(negedge clk);
    check(!vec_valid && !iack_out, "R7 release", int'(vec_valid) + int'(iack_out), 0);
    check_irq(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7151));
    rst_n = 1'b0; src_flag = '0; src_en = '1; base_sel = 4'd0;
    console_en = 1'b0; level_sel = 2'd0; hi_req_mon = '0; iack_in = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(irq_out == '0 && vec_out == '0 && !vec_valid && !iack_out, "R10",
          int'(irq_out) + int'(vec_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 acknowledge with nothing pending
    do_ack("R9 empty");

    // R1 flag without enable, then enable rising under a held flag
    src_en = 8'b1111_1100;
    pulse_src(8'b0000_0001);
    @(negedge clk);
    check_irq("R1 flag alone");
    src_flag = 8'b0000_0010;
    @(negedge clk);
    check_irq("R1 enable low");
    src_en[1] = 1'b1;
    @(negedge clk);
    mpend[1] = 1'b1;
    check_irq("R1 enable rise");
    src_flag = '0; src_en = '1;
    base_sel = 4'd3;
    do_ack("R1 R5 rx1 vector");

    // R4 full drain in priority order, R5 vectors, R3 on level 7
    base_sel = 4'd15; level_sel = 2'd3;
    pulse_src(8'hFF);
    check_irq("R3 level7");
    for (int k = 0; k < 8; k++) do_ack("R4 R5 order");
    do_ack("R9 drained");

    // R6 console vectors ignore base
    console_en = 1'b1; base_sel = 4'd5; level_sel = 2'd1;
    pulse_src(8'b1000_1000);
    do_ack("R6 console rx");
    do_ack("R6 console tx");
    console_en = 1'b0;

    // R8 same level does not block, higher level does
    pulse_src(8'b0001_0001);
    hi_req_mon = 4'b0011;
    do_ack("R8 same level");
    hi_req_mon = 4'b0100;
    do_ack("R8 blocked");
    check_irq("R8 still pending");
    hi_req_mon = '0;
    do_ack("R8 after block");

    // R2 enable drop removes the request
    pulse_src(8'b0000_0100);
    check_irq("R2 set");
    src_en[2] = 1'b0;
    @(negedge clk);
    mpend &= src_en;
    check_irq("R2 dropped");
    src_en[2] = 1'b1;
    @(negedge clk);
    check_irq("R2 stays dropped");
    do_ack("R2 R9 pass");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      base_sel   = 4'($urandom_range(0, 15));
      console_en = 1'($urandom_range(0, 1));
      level_sel  = 2'($urandom_range(0, 3));
      hi_req_mon = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
      if ($urandom_range(0, 1) == 1) pulse_src(8'($urandom_range(0, 255)));
      @(negedge clk);
      check_irq("R3 random");
      if ($urandom_range(0, 2) != 0) do_ack("R4 R5 R6 R8 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule